// File: doc/BRIEF.md
# Video Address Space Decoder with Nametable and Palette Folding

This block serves the 14-bit address space seen by a picture processor. An access arrives as an address, a read enable, a write enable and write data. The block reduces the address to 14 bits and sends it to one of three places. The lowest 8 KB holds pattern data and is forwarded to a cartridge port. The next region reaches a 2 KB nametable RAM held inside the block. The top 256 bytes reach a 32-byte palette RAM, also held inside the block.

Nametable accesses pass through a fold chosen by a 3-bit mirroring mode that the cartridge supplies. The fold maps each of four logical 1 KB screens onto a physical screen. Palette accesses pass through the backdrop alias: the four sprite-side backdrop slots share storage with the matching background slots. Read data is combinational. Writes commit on the rising clock edge. Both internal RAMs clear to zero under reset.

Top module: `vmem_map`

## Requirements
- R1: Address bits above bit 13 of `vaddr` are ignored: any access behaves exactly like the same access with those bits cleared.
- R2: Accesses below 0x2000 drive `cart_rd` (read) or `cart_wr` (write) high in the same cycle, with `cart_addr` equal to the address bits 12:0 and `cart_wdata` equal to `wdata`. Read data then equals `cart_rdata`. Neither internal RAM changes. At or above 0x2000 both cartridge strobes stay low.
- R3: Nametable region 0x2000..0x3EFF: bits 11:10 of the address pick logical screen L and bits 9:0 are the offset. With `mirror_mode` = 0 (horizontal), screens 0,1,2,3 map to physical 0,0,1,1.
- R4: With `mirror_mode` = 1 (vertical), logical screens 0,1,2,3 map to physical 0,1,0,1.
- R5: With `mirror_mode` = 2, all screens map to physical 0. With `mirror_mode` = 3, all screens map to physical 1.
- R6: With `mirror_mode` = 4, screens map 0,1,2,3 to physical 0,1,2,3. The RAM index is (physical*1024 + offset) mod 2048, so screens 2 and 3 share storage with 0 and 1. Modes 5, 6 and 7 behave as mode 4.
- R7: Palette region 0x3F00..0x3FFF uses only address bits 4:0 as the palette index, so the region repeats every 32 bytes.
- R8: A palette index of 0x10, 0x14, 0x18 or 0x1C accesses the entry 0x10 lower (0x00, 0x04, 0x08, 0x0C), for both reads and writes. Every other index keeps its own entry.
- R9: A clock edge with `rst_n` low clears every nametable and palette byte to zero.
- R10: `rdata` shows the selected byte in the same cycle as `rd_en` and is 0 while `rd_en` is low. A write with `wr_en` high is visible to a read from the next cycle on. An access with `wr_en` low changes nothing.
- R11: Within the nametable region only address bits 11:0 matter, so 0x3000..0x3EFF reaches the same bytes as 0x2000..0x2EFF under the same mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears both RAMs |
| vaddr | input | 16 | Access address; only bits 13:0 are used |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when no read |
| mirror_mode | input | 3 | Nametable fold: 0 horiz, 1 vert, 2 single low, 3 single high, 4..7 four-screen |
| cart_addr | output | 13 | Pattern-region address to the cartridge |
| cart_rd | output | 1 | Cartridge read strobe |
| cart_wr | output | 1 | Cartridge write strobe |
| cart_wdata | output | 8 | Write data to the cartridge |
| cart_rdata | input | 8 | Read data from the cartridge |

## Verification
Read data and cartridge strobes are combinational, so they are due in the same cycle as the request. The bench drives each access on the falling edge and samples these outputs a quarter period later, before the next rising edge. A write lands on the rising edge that closes its cycle. Its effect is therefore first checked by a read driven on the following falling edge, against bench models of both RAMs that apply the fold and alias rules. A reset clears the model at the same edge at which it clears the design.

// File: rtl/vmem_pkg.sv
// Package: shared sizes, region type and the mirroring lookup.
// Assumes a 14-bit video address space with 1 KB logical screens.
package vmem_pkg;

    localparam int VMEM_AW   = 14;   // effective address width
    localparam int CART_AW   = 13;   // pattern region width
    localparam int SCREEN_AW = 10;   // 1 KB per logical screen

    typedef enum logic [1:0] {
        REG_CART = 2'd0,
        REG_NT   = 2'd1,
        REG_PAL  = 2'd2
    } region_e;

    typedef enum logic [2:0] {
        MIR_HORZ   = 3'd0,
        MIR_VERT   = 3'd1,
        MIR_ONE_LO = 3'd2,
        MIR_ONE_HI = 3'd3,
        MIR_FOUR   = 3'd4
    } mirror_e;

    // Physical screen for a logical screen under a mode; 5..7 act as four-screen.
    function automatic logic [1:0] phys_screen(input logic [2:0] mode,
                                               input logic [1:0] lscreen);
        logic [1:0] p;
        case (mode)
            MIR_HORZ:   p = {1'b0, lscreen[1]};
            MIR_VERT:   p = {1'b0, lscreen[0]};
            MIR_ONE_LO: p = 2'd0;
            MIR_ONE_HI: p = 2'd1;
            default:    p = lscreen;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/vmem_decode.sv
// Module: vmem_decode
// Splits a video address into region, cartridge address, folded nametable
// index and aliased palette index. Purely combinational; clk/rst_n only
// clock the embedded assertions. Assumes NT_AW >= SCREEN_AW + 1.
module vmem_decode
    import vmem_pkg::*;
#(
    parameter int VADDR_W = 16,
    parameter int NT_AW   = 11,
    parameter int PAL_AW  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VADDR_W-1:0] vaddr,
    input  logic [2:0]         mirror_mode,
    output region_e            region,
    output logic [CART_AW-1:0] cart_idx,
    output logic [NT_AW-1:0]   nt_idx,
    output logic [PAL_AW-1:0]  pal_idx
);
    localparam int NT_REL_W = SCREEN_AW + 2;      // 12-bit nametable offset
    localparam int HI_W     = VMEM_AW - 8;        // page bits for region check

    logic [VMEM_AW-1:0]  a14;
    logic [NT_REL_W-1:0] nt_rel;
    logic [1:0]          lscreen;
    logic [1:0]          pscreen;
    logic [PAL_AW-1:0]   pal_raw;
    logic [NT_REL_W-1:0] nt_full;

    // Purpose: reduce the address and classify its region.
    always_comb begin
        a14 = vaddr[VMEM_AW-1:0];
        if (!a14[VMEM_AW-1])
            region = REG_CART;
        else if (a14[VMEM_AW-1:8] == {HI_W{1'b1}})
            region = REG_PAL;
        else
            region = REG_NT;
    end

    assign cart_idx = a14[CART_AW-1:0];

    // Purpose: fold a logical screen onto physical storage by mode.
    always_comb begin
        nt_rel  = a14[NT_REL_W-1:0];
        lscreen = nt_rel[NT_REL_W-1:SCREEN_AW];
        pscreen = phys_screen(mirror_mode, lscreen);
        nt_full = {pscreen, nt_rel[SCREEN_AW-1:0]};
        nt_idx  = nt_full[NT_AW-1:0];
    end

    // Purpose: apply the backdrop alias to the upper palette half.
    always_comb begin
        pal_raw = a14[PAL_AW-1:0];
        pal_idx = pal_raw;
        if (pal_raw[PAL_AW-1] && pal_raw[1:0] == 2'b00)
            pal_idx[PAL_AW-1] = 1'b0;
    end

    // R8: backdrop slots in the upper half never reach upper storage
    p_backdrop_alias_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_PAL && vaddr[1:0] == 2'b00) |-> !pal_idx[PAL_AW-1]);

    // R8: non-backdrop entries keep their own index
    p_no_alias_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_PAL && vaddr[1:0] != 2'b00) |-> pal_idx == vaddr[PAL_AW-1:0]);

    // R5: single-screen modes pin the physical screen
    p_single_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_NT && mirror_mode == 3'd2) |-> !nt_idx[SCREEN_AW]);
    p_single_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_NT && mirror_mode == 3'd3) |-> nt_idx[SCREEN_AW]);

    // R3: the offset within a screen passes unchanged
    p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_NT) |-> nt_idx[SCREEN_AW-1:0] == vaddr[SCREEN_AW-1:0]);

endmodule

// File: rtl/vmem_ram.sv
// Module: vmem_ram
// Single-port byte RAM with combinational read and synchronous write.
// A synchronous active-low reset clears every entry. Assumes a small DEPTH.
module vmem_ram #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: clear all entries in reset, else commit a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rd_data = mem[idx];

    // R10: a written byte is visible at that index on the next cycle
    p_write_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (idx != $past(idx)) || (rd_data == $past(wdata)));

    // R9: after a reset edge any entry reads as zero
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0);

endmodule

// File: rtl/vmem_map.sv
// Module: vmem_map (top)
// Video address map: pattern accesses go to the cartridge port, nametable
// accesses to a mirrored 2 KB RAM, palette accesses to an aliased 32-byte RAM.
// Assumes at most one access per cycle; rd_en and wr_en may both be high.
module vmem_map
    import vmem_pkg::*;
#(
    parameter int VADDR_W   = 16,
    parameter int DATA_W    = 8,
    parameter int NT_BYTES  = 2048,
    parameter int PAL_BYTES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VADDR_W-1:0] vaddr,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [2:0]         mirror_mode,
    output logic [CART_AW-1:0] cart_addr,
    output logic               cart_rd,
    output logic               cart_wr,
    output logic [DATA_W-1:0]  cart_wdata,
    input  logic [DATA_W-1:0]  cart_rdata
);
    localparam int NT_AW  = $clog2(NT_BYTES);
    localparam int PAL_AW = $clog2(PAL_BYTES);

    region_e            region;
    logic [NT_AW-1:0]   nt_idx;
    logic [PAL_AW-1:0]  pal_idx;
    logic [DATA_W-1:0]  nt_q;
    logic [DATA_W-1:0]  pal_q;
    logic               nt_we;
    logic               pal_we;

    vmem_decode #(
        .VADDR_W (VADDR_W),
        .NT_AW   (NT_AW),
        .PAL_AW  (PAL_AW)
    ) i_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .vaddr       (vaddr),
        .mirror_mode (mirror_mode),
        .region      (region),
        .cart_idx    (cart_addr),
        .nt_idx      (nt_idx),
        .pal_idx     (pal_idx)
    );

    vmem_ram #(.DEPTH(NT_BYTES), .DATA_W(DATA_W)) i_nt_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (nt_idx),
        .we      (nt_we),
        .wdata   (wdata),
        .rd_data (nt_q)
    );

    vmem_ram #(.DEPTH(PAL_BYTES), .DATA_W(DATA_W)) i_pal_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (pal_idx),
        .we      (pal_we),
        .wdata   (wdata),
        .rd_data (pal_q)
    );

    // Purpose: steer write and strobe enables to the selected target.
    always_comb begin
        nt_we      = wr_en && (region == REG_NT);
        pal_we     = wr_en && (region == REG_PAL);
        cart_rd    = rd_en && (region == REG_CART);
        cart_wr    = wr_en && (region == REG_CART);
        cart_wdata = wdata;
    end

    // Purpose: return the selected byte, or zero when no read is requested.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (region)
                REG_CART: rdata = cart_rdata;
                REG_NT:   rdata = nt_q;
                REG_PAL:  rdata = pal_q;
                default:  rdata = '0;
            endcase
        end
    end

    // R2: no cartridge strobe for addresses at or above 0x2000
    p_cart_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vaddr[VMEM_AW-1] |-> !cart_rd && !cart_wr);

    // R2: internal RAMs are never written by a pattern-region access
    p_cart_no_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cart_wr |-> !nt_we && !pal_we);

    // R10: idle read port returns zero
    p_read_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

endmodule

// File: tb/test_vmem_map.sv
// Bench for vmem_map: directed corner cases plus seeded random accesses,
// checked against RAM models that apply the fold and alias rules.
module test_vmem_map;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] vaddr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [2:0]  mirror_mode = '0;
    logic [12:0] cart_addr;
    logic        cart_rd;
    logic        cart_wr;
    logic [7:0]  cart_wdata;
    logic [7:0]  cart_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] nt_m  [2048];
    logic [7:0] pal_m [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Cartridge stand-in: data is a fixed function of the address.
    function automatic logic [7:0] cart_fn(input int a);
        return 8'((a & 'hFF) ^ ((a >> 8) & 'h1F) ^ 'h5A);
    endfunction
    assign cart_rdata = cart_fn(int'(cart_addr));

    vmem_map i_vmem_map (
        .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .mirror_mode(mirror_mode),
        .cart_addr(cart_addr), .cart_rd(cart_rd), .cart_wr(cart_wr),
        .cart_wdata(cart_wdata), .cart_rdata(cart_rdata)
    );

    function automatic int region_of(input int a);
        int a14 = a & 'h3FFF;
        if (a14 < 'h2000) return 0;
        if (a14 < 'h3F00) return 1;
        return 2;
    endfunction

    function automatic int nt_model_idx(input int mode, input int a);
        int rel = ((a & 'h3FFF) - 'h2000) & 'hFFF;
        int scr = rel / 1024;
        int off = rel % 1024;
        int p;
        case (mode)
            0: p = scr / 2;
            1: p = scr % 2;
            2: p = 0;
            3: p = 1;
            default: p = scr;
        endcase
        return (p * 1024 + off) % 2048;
    endfunction

    function automatic int pal_model_idx(input int a);
        int rel = ((a & 'h3FFF) - 'h3F00) & 'h1F;
        if (rel >= 16 && rel % 4 == 0) rel = rel - 16;
        return rel;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 2048; i++) nt_m[i] = '0;
        for (int i = 0; i < 32; i++) pal_m[i] = '0;
    endtask

    // One access cycle: drive on falling edge, check a quarter period later.
    task automatic access(input int a, input bit rd, input bit wr,
                          input logic [7:0] d, input int mode, input string req);
        int reg_k = region_of(a);
        int exp_rd;
        @(negedge clk);
        vaddr = 16'(a); rd_en = rd; wr_en = wr; wdata = d; mirror_mode = 3'(mode);
        #(CLK_PERIOD/4);
        if (!rd) exp_rd = 0;
        else if (reg_k == 0) exp_rd = int'(cart_fn(a & 'h1FFF));
        else if (reg_k == 1) exp_rd = int'(nt_m[nt_model_idx(mode, a)]);
        else exp_rd = int'(pal_m[pal_model_idx(a)]);
        chk(rdata == 8'(exp_rd), req, int'(rdata), exp_rd);
        chk(cart_rd == (rd && reg_k == 0) && cart_wr == (wr && reg_k == 0),
            "R2 strobes", {cart_rd, cart_wr}, {rd && reg_k == 0, wr && reg_k == 0});
        if (wr && reg_k == 0)
            chk(cart_addr == 13'(a & 'h1FFF) && cart_wdata == d, "R2 cart write",
                {cart_addr, cart_wdata}, {13'(a & 'h1FFF), d});
        if (wr && reg_k == 1) nt_m[nt_model_idx(mode, a)] = d;
        if (wr && reg_k == 2) pal_m[pal_model_idx(a)] = d;
    endtask

    task automatic wr8(input int a, input logic [7:0] d, input int mode, input string req);
        access(a, 1'b0, 1'b1, d, mode, req);
    endtask
    task automatic rd8(input int a, input int mode, input string req);
        access(a, 1'b1, 1'b0, 8'h00, mode, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        clear_model();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state, then clearing after data was stored
        rd8('h2000, 0, "R9 reset nametable");
        rd8('h3F00, 0, "R9 reset palette");
        wr8('h2123, 8'hAB, 4, "R9 setup");
        wr8('h3F07, 8'hCD, 4, "R9 setup");
        rd8('h2123, 4, "R9 stored");
        do_reset();
        rd8('h2123, 4, "R9 cleared nametable");
        rd8('h3F07, 4, "R9 cleared palette");

        // R3 horizontal
        wr8('h2005, 8'h11, 0, "R3 write");
        rd8('h2405, 0, "R3 screen1 aliases 0");
        wr8('h2C05, 8'h22, 0, "R3 write");
        rd8('h2805, 0, "R3 screen2 aliases 3");
        rd8('h2005, 0, "R3 screen0 kept");
        // R4 vertical
        wr8('h2010, 8'h33, 1, "R4 write");
        rd8('h2810, 1, "R4 screen2 aliases 0");
        wr8('h2C11, 8'h44, 1, "R4 write");
        rd8('h2411, 1, "R4 screen1 aliases 3");
        // R5 single screens
        wr8('h2C20, 8'h55, 2, "R5 write");
        rd8('h2020, 2, "R5 single low");
        wr8('h2030, 8'h66, 3, "R5 write");
        rd8('h2430, 3, "R5 single high");
        rd8('h2830, 0, "R5 high is physical 1");
        // R6 four-screen, fold, and modes 5..7
        wr8('h2040, 8'h77, 4, "R6 write");
        wr8('h2440, 8'h88, 4, "R6 write");
        rd8('h2840, 4, "R6 screen2 folds to 0");
        rd8('h2C40, 4, "R6 screen3 folds to 1");
        rd8('h2C40, 5, "R6 mode5");
        rd8('h2840, 7, "R6 mode7");
        // R11 upper nametable mirror
        rd8('h3040, 4, "R11 0x3040 equals 0x2040");
        // R7 palette repeat
        wr8('h3F05, 8'h99, 0, "R7 write");
        rd8('h3F25, 0, "R7 repeat 0x20");
        rd8('h3FE5, 0, "R7 repeat 0xE0");
        // R8 backdrop alias
        wr8('h3F10, 8'hA1, 0, "R8 write");
        rd8('h3F00, 0, "R8 0x10 onto 0x00");
        wr8('h3F0C, 8'hA2, 0, "R8 write");
        rd8('h3F1C, 0, "R8 0x1C onto 0x0C");
        wr8('h3F11, 8'hA3, 0, "R8 write");
        rd8('h3F01, 0, "R8 0x11 not aliased");
        // R1 upper bits ignored
        rd8('hFF05, 0, "R1 upper bits palette");
        rd8('hE005, 0, "R1 upper bits nametable");
        // R2 cartridge pass-through
        rd8('h0123, 0, "R2 cart read");
        wr8('h1ABC, 8'h5C, 0, "R2 cart write");
        rd8('hC0F0, 0, "R2 R1 cart with upper bits");
        // R10 idle read and write without enable
        access('h2005, 1'b0, 1'b0, 8'hEE, 0, "R10 idle read zero");
        access('h2005, 1'b0, 1'b0, 8'hEE, 0, "R10 no-enable write");
        rd8('h2005, 0, "R10 unchanged after no-enable write");
        access('h3F03, 1'b1, 1'b1, 8'h3C, 0, "R10 read-before-write");
        rd8('h3F03, 0, "R10 write visible next cycle");

        // Seeded random traffic across all regions and modes
        for (int n = 0; n < 3000; n++) begin
            int sel = $urandom_range(0, 9);
            int a;
            int hi = $urandom_range(0, 3) << 14;
            if (sel < 1) a = $urandom_range(0, 'h1FFF);
            else if (sel < 6) a = $urandom_range('h2000, 'h3EFF);
            else a = $urandom_range('h3F00, 'h3FFF);
            access(a | hi, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   8'($urandom_range(0, 255)), $urandom_range(0, 7), "R3 R6 R8 random");
        end

        do_reset();
        rd8('h2C40, 4, "R9 cleared after traffic");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule